// File: doc/BRIEF.md
# Streaming write allocation controller

This block sits beside a cache's write path and picks, for each incoming write, how the cache should treat it. It follows one stream of contiguous writes. Each write's start address is compared with the address where the previous write ended. The block counts how many contiguous bytes the stream has covered so far. As that count grows, the policy steps up in three stages:

- allocate normally;
- merge writes before sending a line request;
- merge writes and skip allocation in the cache altogether.

A write that breaks the stream drops the policy back to normal allocation.

Next to the stream tracker is a small fully associative table of per-line hold counters. When the cache is about to send a line-write request, it queries the table with the line address. A hold answer tells the cache to wait so that more bytes of the line can merge first. Each line can be held only a bounded number of times. The cache clears a line's entry once the request for that line has been serviced.

Top module: `wr_stream_alloc_ctrl`

## Requirements
- R1: While reset is active and in the cycle after it, `allocate_o` is 1 and `coalesce_o` is 0. The expected next address is zero, so the first write at address 0 counts as contiguous.
- R2: The mode is one of three values: normal, merge, and merge-without-allocation.
  - `coalesce_o` is 1 in merge and merge-without-allocation.
  - `allocate_o` is 1 in normal and merge.
  - Both outputs are registered and reflect a write from the cycle after it is accepted.
- R3: An accepted write whose `wr_addr` equals the expected next address adds `wr_size` (1 to LINE_BYTES) to the contiguous count. The expected next address becomes `wr_addr + wr_size` (modulo 2^ADDR_W).
- R4: The mode enters merge when the contiguous count becomes strictly greater than COALESCE_LINES*LINE_BYTES. A count equal to that limit keeps normal mode. A contiguous write never leaves merge.
- R5: The mode enters merge-without-allocation when the count becomes strictly greater than NOALLOC_LINES*LINE_BYTES. A count equal to that limit stays in merge.
- R6: In merge-without-allocation, a contiguous write leaves the mode unchanged. The count stops growing, and the expected next address still advances.
- R7: A write whose address differs from the expected next address returns the mode to normal. It restarts the count at that write's size and sets the expected next address to `wr_addr + wr_size`.
- R8: A query for a line with no table entry allocates a free entry, provided one exists and the same line is not being cleared in that cycle. Over its lifetime, the line receives a hold answer on exactly DELAY_THRESH queries; later queries answer 0.
- R9: When all DELAY_DEPTH entries are in use, a query for a new line answers 0 and creates no entry.
- R10: A clear for a line removes its entry, so a later query for that line starts a fresh hold budget. A clear for a line not in the table changes nothing. A clear takes precedence over a query of the same line in the same cycle.
- R11: `dq_hold` is combinational: it answers in the same cycle as `dq_valid` and is 0 whenever `dq_valid` is 0.
- R12: Cycles without an accepted write leave `coalesce_o` and `allocate_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A write is presented this cycle |
| wr_addr | input | ADDR_W | Start byte address of the write |
| wr_size | input | SIZE_W | Byte count of the write, 1 to LINE_BYTES |
| dq_valid | input | 1 | Hold query for a line this cycle |
| dq_line | input | LINE_W | Line address being queried |
| dq_hold | output | 1 | 1: hold back this line's write request |
| dc_valid | input | 1 | Clear request for a line this cycle |
| dc_line | input | LINE_W | Line address whose hold entry is removed |
| coalesce_o | output | 1 | Writes should be merged before issue |
| allocate_o | output | 1 | Writes may allocate in the cache |

## Verification
The bench builds the block with these parameter values:

| Parameter | Value | Byte limit |
|---|---|---|
| ADDR_W | 16 | — |
| LINE_BYTES | 16 | — |
| COALESCE_LINES | 2 | 32 |
| NOALLOC_LINES | 3 | 48 |
| DELAY_THRESH | 2 | — |
| DELAY_DEPTH | 4 | — |

With these values, a handful of writes reaches both mode limits, including the exact limit values where the mode must not change yet. A four-entry table fills after four distinct lines, so queries against a full table and slot reuse after a clear occur often in the random phase. A threshold of two shows both the last held query and the first released one for each line.

// File: rtl/wsa_pkg.sv
// Shared types for the streaming write allocation controller.
// Assumes nothing beyond a two-bit encoding of the three write policies.
package wsa_pkg;
    typedef enum logic [1:0] {
        WM_ALLOC   = 2'd0,
        WM_COAL    = 2'd1,
        WM_NOALLOC = 2'd2
    } wmode_e;
endpackage

// File: rtl/wsa_stream_tracker.sv
// Follows one stream of contiguous writes and steps the write policy up
// as the contiguous byte count crosses two limits.
// Assumes wr_size lies in 1..LINE_BYTES and COAL_BYTES <= NOALLOC_BYTES.
module wsa_stream_tracker
    import wsa_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int SIZE_W        = 7,
    parameter int CNT_W         = 10,
    parameter int COAL_BYTES    = 128,
    parameter int NOALLOC_BYTES = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    output wmode_e            mode_q,
    output logic [ADDR_W-1:0] exp_q
);
    localparam logic [CNT_W-1:0] COAL_LIM = CNT_W'(COAL_BYTES);
    localparam logic [CNT_W-1:0] NA_LIM   = CNT_W'(NOALLOC_BYTES);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  sum;
    logic [ADDR_W-1:0] addr_nxt;
    logic              contig;

    // Purpose: contiguity test, running byte sum and next expected address.
    always_comb begin
        contig   = (wr_addr == exp_q);
        sum      = cnt_q + CNT_W'(wr_size);
        addr_nxt = wr_addr + ADDR_W'(wr_size);
    end

    // Purpose: update stream state and policy on each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WM_ALLOC;
            cnt_q  <= '0;
            exp_q  <= '0;
        end else if (wr_valid) begin
            exp_q <= addr_nxt;
            if (!contig) begin
                mode_q <= WM_ALLOC;
                cnt_q  <= CNT_W'(wr_size);
            end else if (mode_q != WM_NOALLOC) begin
                cnt_q <= sum;
                if (sum > NA_LIM) begin
                    mode_q <= WM_NOALLOC;
                end else if (sum > COAL_LIM) begin
                    mode_q <= WM_COAL;
                end
            end
        end
    end
endmodule

// File: rtl/wsa_prio_enc.sv
// Lowest-index-first priority encoder used to pick a free table slot.
// Assumes N >= 1; idx is zero when no request bit is set.
module wsa_prio_enc #(
    parameter int N = 8,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Purpose: scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
        end
        any = |req;
    end
endmodule

// File: rtl/wsa_delay_table.sv
// Fully associative table of per-line hold counters.
// A query that misses allocates the lowest free entry, with THRESH holds
// budgeted and the first one spent at once. A query that hits spends one
// hold if any remain. A clear removes the matching entry and wins over a
// same-cycle query. Assumes at most one entry per line, which allocation
// only on a miss guarantees.
module wsa_delay_table #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 8,
    parameter int THRESH = 4,
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int DCNT_W = (THRESH < 1) ? 1 : $clog2(THRESH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              q_valid,
    input  logic [LINE_W-1:0] q_line,
    output logic              hold,
    input  logic              c_valid,
    input  logic [LINE_W-1:0] c_line
);
    localparam logic [DCNT_W-1:0] CNT_INIT = DCNT_W'((THRESH > 0) ? THRESH - 1 : 0);
    localparam bit HOLD_ON_ALLOC = (THRESH > 0);

    logic [DEPTH-1:0]             ent_v;
    logic [DEPTH-1:0][LINE_W-1:0] ent_line;
    logic [DEPTH-1:0][DCNT_W-1:0] ent_cnt;
    logic [DEPTH-1:0]             hit_vec;
    logic [DEPTH-1:0]             clr_vec;
    logic [DCNT_W-1:0]            hit_cnt;
    logic [IDX_W-1:0]             free_idx;
    logic                         free_any;
    logic                         any_hit;
    logic                         alloc_en;

    // Per-entry tag comparators for query and clear.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = ent_v[i] && (ent_line[i] == q_line);
        assign clr_vec[i] = ent_v[i] && (ent_line[i] == c_line);
    end

    wsa_prio_enc #(.N(DEPTH)) u_free (
        .req (~ent_v),
        .idx (free_idx),
        .any (free_any)
    );

    // Purpose: gather the hit counter and form the hold answer and allocate strobe.
    always_comb begin
        hit_cnt = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (hit_vec[k]) hit_cnt = hit_cnt | ent_cnt[k];
        end
        any_hit  = |hit_vec;
        alloc_en = q_valid && !any_hit && free_any &&
                   !(c_valid && (c_line == q_line));
        hold     = q_valid && (any_hit ? (hit_cnt != '0)
                                       : (free_any && HOLD_ON_ALLOC));
    end

    // Purpose: clear, allocate or decrement each entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v    <= '0;
            ent_line <= '0;
            ent_cnt  <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (c_valid && clr_vec[k]) begin
                    ent_v[k] <= 1'b0;
                end else if (alloc_en && (free_idx == IDX_W'(k))) begin
                    ent_v[k]    <= 1'b1;
                    ent_line[k] <= q_line;
                    ent_cnt[k]  <= CNT_INIT;
                end else if (q_valid && hit_vec[k] && (ent_cnt[k] != '0)) begin
                    ent_cnt[k] <= ent_cnt[k] - DCNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/wr_stream_alloc_ctrl.sv
// Top of the streaming write allocation controller.
// Combines the stream tracker, which drives the two policy outputs, with
// the per-line hold table. Assumes LINE_BYTES is a power of two and
// 1 <= COALESCE_LINES <= NOALLOC_LINES.
module wr_stream_alloc_ctrl
    import wsa_pkg::*;
#(
    parameter int ADDR_W         = 32,
    parameter int LINE_BYTES     = 64,
    parameter int COALESCE_LINES = 2,
    parameter int NOALLOC_LINES  = 4,
    parameter int DELAY_THRESH   = 3,
    parameter int DELAY_DEPTH    = 8,
    localparam int SIZE_W = $clog2(LINE_BYTES) + 1,
    localparam int LINE_W = ADDR_W - $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SIZE_W-1:0] wr_size,
    input  logic              dq_valid,
    input  logic [LINE_W-1:0] dq_line,
    output logic              dq_hold,
    input  logic              dc_valid,
    input  logic [LINE_W-1:0] dc_line,
    output logic              coalesce_o,
    output logic              allocate_o
);
    localparam int COAL_BYTES = COALESCE_LINES * LINE_BYTES;
    localparam int NA_BYTES   = NOALLOC_LINES * LINE_BYTES;
    localparam int CNT_W      = $clog2(NA_BYTES + LINE_BYTES + 1);

    wmode_e            mode_q;
    logic [ADDR_W-1:0] exp_addr;

    wsa_stream_tracker #(
        .ADDR_W        (ADDR_W),
        .SIZE_W        (SIZE_W),
        .CNT_W         (CNT_W),
        .COAL_BYTES    (COAL_BYTES),
        .NOALLOC_BYTES (NA_BYTES)
    ) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_size  (wr_size),
        .mode_q   (mode_q),
        .exp_q    (exp_addr)
    );

    wsa_delay_table #(
        .LINE_W (LINE_W),
        .DEPTH  (DELAY_DEPTH),
        .THRESH (DELAY_THRESH)
    ) u_dly (
        .clk     (clk),
        .rst_n   (rst_n),
        .q_valid (dq_valid),
        .q_line  (dq_line),
        .hold    (dq_hold),
        .c_valid (dc_valid),
        .c_line  (dc_line)
    );

    // Purpose: decode the registered mode into the two policy outputs.
    always_comb begin
        coalesce_o = (mode_q != WM_ALLOC);
        allocate_o = (mode_q != WM_NOALLOC);
    end
endmodule

// File: rtl/wsa_checker.sv
// Property checker for wr_stream_alloc_ctrl, bound into every instance.
// Assumes exp_addr is the tracker's expected-next-address register.
module wsa_checker #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [SIZE_W-1:0] wr_size,
    input logic [ADDR_W-1:0] exp_addr,
    input logic              dq_valid,
    input logic              dq_hold,
    input logic              coalesce_o,
    input logic              allocate_o
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (allocate_o && !coalesce_o));

    assert_next_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (exp_addr == ($past(wr_addr) + ADDR_W'($past(wr_size)))));

    assert_coal_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_addr == exp_addr) && coalesce_o) |=> coalesce_o);

    assert_noalloc_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_addr == exp_addr) && !allocate_o) |=> !allocate_o);

    assert_break_resets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (wr_addr != exp_addr)) |=> (allocate_o && !coalesce_o));

    assert_hold_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dq_hold |-> dq_valid);

    assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> ($stable(coalesce_o) && $stable(allocate_o)));
endmodule

bind wr_stream_alloc_ctrl wsa_checker #(
    .ADDR_W (ADDR_W),
    .SIZE_W (SIZE_W)
) u_wsa_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_size    (wr_size),
    .exp_addr   (exp_addr),
    .dq_valid   (dq_valid),
    .dq_hold    (dq_hold),
    .coalesce_o (coalesce_o),
    .allocate_o (allocate_o)
);

// File: tb/wr_stream_alloc_ctrl_tb_top.sv
// Bench: a behavioural reference model (integers and an associative table)
// is stepped alongside the design and compared on every clock.
module wr_stream_alloc_ctrl_tb_top;
    localparam int ADDR_W = 16;
    localparam int LB     = 16;
    localparam int CL     = 2;
    localparam int NL     = 3;
    localparam int THR    = 2;
    localparam int DEP    = 4;
    localparam int SIZE_W = 5;
    localparam int LINE_W = 12;
    localparam int CO_B   = CL * LB;
    localparam int NA_B   = NL * LB;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [SIZE_W-1:0] wr_size = '0;
    logic              dq_valid = 1'b0;
    logic [LINE_W-1:0] dq_line = '0;
    logic              dq_hold;
    logic              dc_valid = 1'b0;
    logic [LINE_W-1:0] dc_line = '0;
    logic              coalesce_o;
    logic              allocate_o;

    int checks = 0;
    int errors = 0;

    // Reference model state
    int m_mode = 0;
    int m_cnt  = 0;
    int m_next = 0;
    int m_tbl[int];

    always #10 clk = ~clk;

    wr_stream_alloc_ctrl #(
        .ADDR_W(ADDR_W), .LINE_BYTES(LB), .COALESCE_LINES(CL),
        .NOALLOC_LINES(NL), .DELAY_THRESH(THR), .DELAY_DEPTH(DEP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_size(wr_size), .dq_valid(dq_valid), .dq_line(dq_line),
        .dq_hold(dq_hold), .dc_valid(dc_valid), .dc_line(dc_line),
        .coalesce_o(coalesce_o), .allocate_o(allocate_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, check the hold answer, advance
    // the model, then check the policy outputs just after the rising edge.
    task automatic step(input string tag, input bit w, input int a, input int s,
                        input bit q, input int ql, input bit c, input int cl);
        int exp_hold;
        @(negedge clk);
        wr_valid = w;  wr_addr = ADDR_W'(a);  wr_size = SIZE_W'(s);
        dq_valid = q;  dq_line = LINE_W'(ql);
        dc_valid = c;  dc_line = LINE_W'(cl);
        #1;
        exp_hold = 0;
        if (q) begin
            if (m_tbl.exists(ql)) begin
                exp_hold = (m_tbl[ql] > 0) ? 1 : 0;
                if (exp_hold == 1) m_tbl[ql] = m_tbl[ql] - 1;
            end else if (m_tbl.num() < DEP) begin
                exp_hold = (THR > 0) ? 1 : 0;
                m_tbl[ql] = (THR > 0) ? THR - 1 : 0;
            end
        end
        if (c && m_tbl.exists(cl)) m_tbl.delete(cl);
        chk({tag, " R11 hold"}, int'(dq_hold), exp_hold);
        if (w) begin
            if (a == m_next) begin
                if (m_mode != 2) begin
                    m_cnt += s;
                    if (m_cnt > NA_B) m_mode = 2;
                    else if (m_cnt > CO_B) m_mode = 1;
                end
            end else begin
                m_mode = 0;
                m_cnt  = s;
            end
            m_next = (a + s) % (1 << ADDR_W);
        end
        @(posedge clk);
        #2;
        chk({tag, " R2 coalesce"}, int'(coalesce_o), (m_mode != 0) ? 1 : 0);
        chk({tag, " R2 allocate"}, int'(allocate_o), (m_mode != 2) ? 1 : 0);
    endtask

    task automatic wr(input string tag, input int a, input int s);
        step(tag, 1'b1, a, s, 1'b0, 0, 1'b0, 0);
    endtask

    task automatic qry(input string tag, input int l);
        step(tag, 1'b0, 0, 1, 1'b1, l, 1'b0, 0);
    endtask

    task automatic clr(input string tag, input int l);
        step(tag, 1'b0, 0, 1, 1'b0, 0, 1'b1, l);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        chk("R1 reset allocate", int'(allocate_o), 1);
        chk("R1 reset coalesce", int'(coalesce_o), 0);
        chk("R1 reset hold", int'(dq_hold), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 3; i++) step("R12 idle", 0, 0, 1, 0, 0, 0, 0);

        wr("R1 R3 first write at zero", 0, 16);
        wr("R4 count at limit", 16, 16);
        wr("R4 above coalesce limit", 32, 8);
        wr("R5 count at limit", 40, 8);
        wr("R5 above no-allocate limit", 48, 1);
        wr("R6 saturate", 49, 16);
        wr("R6 saturate again", 65, 4);
        step("R12 idle in no-allocate", 0, 0, 1, 0, 0, 0, 0);
        wr("R7 break stream", 200, 4);
        wr("R3 restart", 204, 16);
        wr("R4 restart escalate", 220, 16);
        wr("R7 break from merge", 0, 8);
        wr("R3 wrap setup", 16'hFFF8, 8);
        wr("R3 wrapped contiguous", 0, 16);

        qry("R8 first query", 5);
        qry("R8 second query", 5);
        qry("R8 budget spent", 5);
        qry("R8 still spent", 5);
        qry("R8 fill", 6);
        qry("R8 fill", 7);
        qry("R8 fill", 8);
        qry("R9 table full", 9);
        qry("R9 still no entry", 9);
        clr("R10 clear line", 6);
        qry("R10 reuse slot", 9);
        clr("R10 clear absent line", 100);
        qry("R10 others intact", 7);
        qry("R10 others spent", 7);
        clr("R10 clear spent", 5);
        qry("R10 fresh budget", 5);
        step("R10 clear wins same line", 0, 0, 1, 1, 5, 1, 5);
        qry("R10 after same-line clear", 5);

        for (int i = 0; i < 400; i++) begin
            int a, s, r;
            r = int'($urandom_range(0, 99));
            s = int'($urandom_range(1, LB));
            a = (r < 75) ? m_next : int'($urandom_range(0, 16'hFFFF));
            step("R3 R7 R8 R10 random", r < 85, a, s,
                 $urandom_range(0, 1) == 1, int'($urandom_range(0, 9)),
                 $urandom_range(0, 4) == 0, int'($urandom_range(0, 9)));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule